// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the per-processor priority core of an interrupt controller with 256 vectors. It keeps three 256-bit sets: request flags, in-service flags and a trigger-mode flag for each vector. It also holds an 8-bit task priority and a 9-bit spurious register whose top bit enables the block. Vectors arrive from an upstream router through an accept strobe. The core raises a pending line toward the processor when the best request outranks the current processor priority. On an acknowledge strobe it hands out a vector, a spurious vector or a no-vector indication. An end-of-interrupt strobe retires the highest vector in service.

The processor priority is computed continuously from the task priority and the highest in-service vector. Vectors are grouped into classes of 16 by their upper four bits, and the pending decision compares classes. The acknowledge decision compares the full 8-bit values. A running count of accepts that found their vector not already requested is available to whatever tracks delivery.

Top module: `vec_prio_ctrl`

## Requirements
- R1: An accepted vector sets its request flag. Its trigger flag becomes 1 when `acceptLevel` is 1 and 0 when it is 0. When that vector is later acknowledged, `ackLevel` reports the trigger flag.
- R2: Among several requested vectors, acknowledge picks the highest-numbered one.
- R3: `procPrio` equals the task priority when task priority bits [7:4] are greater than or equal to the class (bits [7:4]) of the highest in-service vector, taking 0 when none is in service. Otherwise `procPrio` equals that class followed by four zero bits.
- R4: `intPending` is 1 exactly when the enable bit (spurious register bit 8) is 1, at least one request exists, and either `procPrio` is 0 or bits [7:4] of the highest request exceed `procPrio` bits [7:4].
- R5: When an acknowledge finds the block enabled and a request present, with a nonzero task priority and a highest request numerically not above it, the response has `ackSpur`=1 and `ackVector` equal to spurious register bits [7:0]. No flag changes.
- R6: Any other acknowledge of an enabled block with a request present clears that vector's request flag, sets its in-service flag and returns the vector with `ackSpur`=0 and `ackNone`=0.
- R7: End of interrupt clears the highest set in-service flag. It has no effect when none is set.
- R8: Reset clears all flags, the task priority and the count, and sets the spurious register to 0x0FF, so the block starts disabled. While disabled, `intPending` stays 0 and an acknowledge returns the no-vector indication. Requests are still recorded.
- R9: An acknowledge with no request present, or while disabled, gives `ackNone`=1, `ackVector`=0 and `ackLevel`=0, and changes no state.
- R10: `newReqCount` increases by one on each processed accept whose vector had no request flag set, and is otherwise unchanged.
- R11: Only one flag operation is processed per cycle, with acknowledge first, then end of interrupt, then accept; a lower-ranked strobe in the same cycle is dropped. An acknowledge response (`ackDone`=1 with its fields) appears in the cycle after `ackReq`. Task-priority and spurious-register writes take effect at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| acceptValid | input | 1 | Accept a vector this cycle |
| acceptVec | input | 8 | Vector number to accept |
| acceptLevel | input | 1 | Trigger mode of the accepted vector (1 = level) |
| ackReq | input | 1 | Processor acknowledge strobe |
| eoiReq | input | 1 | End-of-interrupt strobe |
| tprWrite | input | 1 | Write the task priority |
| tprData | input | 8 | New task priority |
| svrWrite | input | 1 | Write the spurious register |
| svrData | input | 9 | New spurious register: bit 8 enable, bits [7:0] spurious vector |
| intPending | output | 1 | Interrupt pending toward the processor |
| procPrio | output | 8 | Current processor priority |
| ackDone | output | 1 | Acknowledge response valid |
| ackVector | output | 8 | Acknowledged or spurious vector |
| ackLevel | output | 1 | Trigger mode of the acknowledged vector |
| ackSpur | output | 1 | Response is the spurious vector |
| ackNone | output | 1 | Response is the no-vector indication |
| newReqCount | output | 16 | Count of accepts that found no prior request |

## Verification
The bench sweeps every task-priority class against every request class, with a low nibble in the task priority. This exposes the difference between the class comparison used for pending and the full-value comparison used for acknowledge: a design that used one rule for both would raise pending where acknowledge turns spurious, or the reverse. Nested in-service vectors are retired one at a time, which catches an end of interrupt that clears the lowest flag or leaves the processor priority stale. Duplicate accepts, acknowledges with nothing requested, disabled operation and colliding strobes catch a miscounting counter, a spurious answer that alters state, and a dropped strobe that still takes effect.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
package vpc_pkg;
  localparam int NUM_VEC = 256;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int CLS_LSB = 4;
  localparam int CLS_W   = VEC_W - CLS_LSB;
  localparam int SVR_W   = VEC_W + 1;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  // strobes from control to datapath, applied at the next clock edge
  typedef struct packed {
    logic setReq;    // record acceptVec as requested
    logic setLevel;  // trigger flag for the recorded vector
    logic takeReq;   // move top request into service
    logic dropSvc;   // retire top in-service vector
    logic wrTpr;
    logic wrSvr;
  } vpc_strobe_t;

  typedef enum logic [1:0] {
    ACK_TAKEN = 2'd0,
    ACK_SPUR  = 2'd1,
    ACK_NONE  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vpc_top_bit.sv
`timescale 1ns/1ps
module vpc_top_bit #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         any,
  output logic [W-1:0] idx
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/vpc_datapath.sv
`timescale 1ns/1ps
module vpc_datapath
  import vpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vpc_strobe_t       stb,
  input  vec_t              accVec,
  input  logic [VEC_W-1:0]  tprIn,
  input  logic [SVR_W-1:0]  svrIn,
  output logic              reqAny,
  output vec_t              reqTop,
  output logic              reqTopLevel,
  output logic              accHit,
  output logic              svcAny,
  output logic [VEC_W-1:0]  tprQ,
  output logic [SVR_W-1:0]  svrQ,
  output logic [VEC_W-1:0]  procPrio
);
  logic [NUM_VEC-1:0] reqBits;
  logic [NUM_VEC-1:0] svcBits;
  logic [NUM_VEC-1:0] trgBits;
  vec_t svcTop;

  vpc_top_bit #(.N(NUM_VEC), .W(VEC_W)) u_reqEnc (
    .bits(reqBits), .any(reqAny), .idx(reqTop)
  );
  vpc_top_bit #(.N(NUM_VEC), .W(VEC_W)) u_svcEnc (
    .bits(svcBits), .any(svcAny), .idx(svcTop)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    logic accHere, takeHere, dropHere;
    logic reqQ, svcQ, trgQ;
    assign accHere  = stb.setReq  && (accVec == vec_t'(g));
    assign takeHere = stb.takeReq && (reqTop == vec_t'(g));
    assign dropHere = stb.dropSvc && (svcTop == vec_t'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ <= 1'b0;
        svcQ <= 1'b0;
        trgQ <= 1'b0;
      end else begin
        if (accHere) begin
          reqQ <= 1'b1;
          trgQ <= stb.setLevel;
        end else if (takeHere) begin
          reqQ <= 1'b0;
        end
        if (takeHere)      svcQ <= 1'b1;
        else if (dropHere) svcQ <= 1'b0;
      end
    end

    assign reqBits[g] = reqQ;
    assign svcBits[g] = svcQ;
    assign trgBits[g] = trgQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tprQ <= '0;
      svrQ <= SVR_W'(8'hFF);
    end else begin
      if (stb.wrTpr) tprQ <= tprIn;
      if (stb.wrSvr) svrQ <= svrIn;
    end
  end

  assign reqTopLevel = trgBits[reqTop];
  assign accHit      = reqBits[accVec];

  // processor priority from task priority and top in-service class
  cls_t svcCls, tprCls;
  always_comb begin
    svcCls = svcAny ? svcTop[VEC_W-1:CLS_LSB] : '0;
    tprCls = tprQ[VEC_W-1:CLS_LSB];
    if (tprCls >= svcCls) procPrio = tprQ;
    else                  procPrio = {svcCls, {CLS_LSB{1'b0}}};
  end
endmodule

// File: rtl/vpc_control.sv
`timescale 1ns/1ps
module vpc_control
  import vpc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               acceptValid,
  input  logic               acceptLevel,
  input  logic               ackReq,
  input  logic               eoiReq,
  input  logic               tprWrite,
  input  logic               svrWrite,
  input  logic               reqAny,
  input  vec_t               reqTop,
  input  logic               reqTopLevel,
  input  logic               accHit,
  input  logic               svcAny,
  input  logic [VEC_W-1:0]   tprQ,
  input  logic [SVR_W-1:0]   svrQ,
  input  logic [VEC_W-1:0]   procPrio,
  output vpc_strobe_t        stb,
  output logic               intPending,
  output logic               ackDone,
  output vec_t               ackVector,
  output logic               ackLevel,
  output logic               ackSpur,
  output logic               ackNone,
  output logic [COUNT_W-1:0] newReqCount
);
  logic enabled, doAck, doEoi, doAcc, blocked;
  ack_kind_e kind;

  assign enabled = svrQ[SVR_W-1];
  assign doAck   = ackReq;
  assign doEoi   = eoiReq && !ackReq;
  assign doAcc   = acceptValid && !ackReq && !eoiReq;
  assign blocked = (tprQ != '0) && (reqTop <= tprQ);

  always_comb begin
    if (!enabled || !reqAny) kind = ACK_NONE;
    else if (blocked)        kind = ACK_SPUR;
    else                     kind = ACK_TAKEN;
  end

  always_comb begin
    stb          = '0;
    stb.setReq   = doAcc;
    stb.setLevel = acceptLevel;
    stb.takeReq  = doAck && (kind == ACK_TAKEN);
    stb.dropSvc  = doEoi && svcAny;
    stb.wrTpr    = tprWrite;
    stb.wrSvr    = svrWrite;
  end

  assign intPending = enabled && reqAny &&
    ((procPrio == '0) ||
     (reqTop[VEC_W-1:CLS_LSB] > procPrio[VEC_W-1:CLS_LSB]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackDone   <= 1'b0;
      ackVector <= '0;
      ackLevel  <= 1'b0;
      ackSpur   <= 1'b0;
      ackNone   <= 1'b0;
    end else begin
      ackDone <= doAck;
      if (doAck) begin
        unique case (kind)
          ACK_TAKEN: begin
            ackVector <= reqTop;
            ackLevel  <= reqTopLevel;
            ackSpur   <= 1'b0;
            ackNone   <= 1'b0;
          end
          ACK_SPUR: begin
            ackVector <= svrQ[VEC_W-1:0];
            ackLevel  <= 1'b0;
            ackSpur   <= 1'b1;
            ackNone   <= 1'b0;
          end
          default: begin
            ackVector <= '0;
            ackLevel  <= 1'b0;
            ackSpur   <= 1'b0;
            ackNone   <= 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                newReqCount <= '0;
    else if (doAcc && !accHit) newReqCount <= newReqCount + 1'b1;
  end
endmodule

// File: rtl/vec_prio_ctrl.sv
`timescale 1ns/1ps
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     acceptValid,
  input  logic [vpc_pkg::VEC_W-1:0] acceptVec,
  input  logic                     acceptLevel,
  input  logic                     ackReq,
  input  logic                     eoiReq,
  input  logic                     tprWrite,
  input  logic [vpc_pkg::VEC_W-1:0] tprData,
  input  logic                     svrWrite,
  input  logic [vpc_pkg::SVR_W-1:0] svrData,
  output logic                     intPending,
  output logic [vpc_pkg::VEC_W-1:0] procPrio,
  output logic                     ackDone,
  output logic [vpc_pkg::VEC_W-1:0] ackVector,
  output logic                     ackLevel,
  output logic                     ackSpur,
  output logic                     ackNone,
  output logic [COUNT_W-1:0]       newReqCount
);
  vpc_strobe_t       stb;
  logic              reqAny, reqTopLevel, accHit, svcAny;
  vec_t              reqTop;
  logic [VEC_W-1:0]  tprQ;
  logic [SVR_W-1:0]  svrQ;

  vpc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accVec(acceptVec),
    .tprIn(tprData), .svrIn(svrData),
    .reqAny(reqAny), .reqTop(reqTop), .reqTopLevel(reqTopLevel),
    .accHit(accHit), .svcAny(svcAny), .tprQ(tprQ), .svrQ(svrQ),
    .procPrio(procPrio)
  );

  vpc_control #(.COUNT_W(COUNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid),
    .acceptLevel(acceptLevel), .ackReq(ackReq), .eoiReq(eoiReq),
    .tprWrite(tprWrite), .svrWrite(svrWrite),
    .reqAny(reqAny), .reqTop(reqTop), .reqTopLevel(reqTopLevel),
    .accHit(accHit), .svcAny(svcAny), .tprQ(tprQ), .svrQ(svrQ),
    .procPrio(procPrio), .stb(stb), .intPending(intPending),
    .ackDone(ackDone), .ackVector(ackVector), .ackLevel(ackLevel),
    .ackSpur(ackSpur), .ackNone(ackNone), .newReqCount(newReqCount)
  );
endmodule

// File: rtl/vpc_checker.sv
`timescale 1ns/1ps
module vpc_checker
  import vpc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               acceptValid,
  input logic               ackReq,
  input logic               eoiReq,
  input logic               svrWrite,
  input logic [SVR_W-1:0]   svrData,
  input logic               intPending,
  input logic [VEC_W-1:0]   procPrio,
  input logic               ackDone,
  input logic [VEC_W-1:0]   ackVector,
  input logic               ackLevel,
  input logic               ackSpur,
  input logic               ackNone,
  input logic [COUNT_W-1:0] newReqCount
);
  // enable bit as seen from the write port
  logic enSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enSeen <= 1'b0;
    else if (svrWrite) enSeen <= svrData[SVR_W-1];
  end

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enSeen |-> !intPending);

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (COUNT_W'(newReqCount - $past(newReqCount)) <= COUNT_W'(1)));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!acceptValid || ackReq || eoiReq) |=> $stable(newReqCount));

  a_r11_ack_follows: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackDone);

  a_r11_ack_cause: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> $past(ackReq));

  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> !(ackSpur && ackNone));

  a_r9_none_blank: assert property (@(posedge clk) disable iff (!rstN)
    (ackDone && ackNone) |-> (ackVector == '0 && !ackLevel));

  a_r6_prio_raised: assert property (@(posedge clk) disable iff (!rstN)
    (ackDone && !ackSpur && !ackNone) |->
      (procPrio[VEC_W-1:CLS_LSB] >= ackVector[VEC_W-1:CLS_LSB]));
endmodule

bind vec_prio_ctrl vpc_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .ackReq(ackReq),
  .eoiReq(eoiReq), .svrWrite(svrWrite), .svrData(svrData),
  .intPending(intPending), .procPrio(procPrio), .ackDone(ackDone),
  .ackVector(ackVector), .ackLevel(ackLevel), .ackSpur(ackSpur),
  .ackNone(ackNone), .newReqCount(newReqCount)
);

// File: tb/vec_prio_ctrl_tb.sv
`timescale 1ns/1ps
module vec_prio_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acceptValid = 1'b0, acceptLevel = 1'b0, ackReq = 1'b0, eoiReq = 1'b0;
  logic tprWrite = 1'b0, svrWrite = 1'b0;
  logic [7:0] acceptVec = '0, tprData = '0;
  logic [8:0] svrData = '0;
  logic intPending, ackDone, ackLevel, ackSpur, ackNone;
  logic [7:0] procPrio, ackVector;
  logic [15:0] newReqCount;

  int nChecks = 0;
  int nFails = 0;

  // reference state built from the requirements
  logic [255:0] mReq = '0, mSvc = '0, mTrg = '0;
  logic [7:0] mTpr = '0;
  logic [8:0] mSvr = 9'h0FF;
  int mCount = 0;

  always #10 clk = ~clk;

  vec_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .acceptVec(acceptVec),
    .acceptLevel(acceptLevel), .ackReq(ackReq), .eoiReq(eoiReq),
    .tprWrite(tprWrite), .tprData(tprData), .svrWrite(svrWrite),
    .svrData(svrData), .intPending(intPending), .procPrio(procPrio),
    .ackDone(ackDone), .ackVector(ackVector), .ackLevel(ackLevel),
    .ackSpur(ackSpur), .ackNone(ackNone), .newReqCount(newReqCount)
  );

  function automatic int topOf(logic [255:0] b);
    int t = -1;
    for (int i = 0; i < 256; i++) if (b[i]) t = i;
    return t;
  endfunction

  function automatic int modelPrio();
    int s = topOf(mSvc);
    int sc = (s < 0) ? 0 : (s >> 4);
    if (int'(mTpr >> 4) >= sc) return int'(mTpr);
    return sc << 4;
  endfunction

  function automatic int modelPend();
    int r = topOf(mReq);
    int p = modelPrio();
    if (!mSvr[8] || r < 0) return 0;
    if (p == 0 || (r >> 4) > (p >> 4)) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState();
    chk("R4", "intPending", 32'(intPending), 32'(modelPend()));
    chk("R3", "procPrio", 32'(procPrio), 32'(modelPrio()));
    chk("R10", "newReqCount", 32'(newReqCount), 32'(mCount & 16'hFFFF));
  endtask

  // one cycle with any mix of strobes; ack > eoi > accept (R11)
  task automatic opCycle(input bit acc, input int v, input bit lvl,
                         input bit ack, input bit eoi);
    int r, s;
    bit expNone, expSpur;
    int expVec, expLvl;
    @(negedge clk);
    acceptValid = acc; acceptVec = 8'(v); acceptLevel = lvl;
    ackReq = ack; eoiReq = eoi;
    r = topOf(mReq);
    expNone = (!mSvr[8] || r < 0);
    expSpur = !expNone && (mTpr != 0) && (r <= int'(mTpr));
    expVec = expNone ? 0 : (expSpur ? int'(mSvr[7:0]) : r);
    expLvl = (expNone || expSpur) ? 0 : int'(mTrg[r]);
    @(posedge clk);
    #1;
    acceptValid = 1'b0; ackReq = 1'b0; eoiReq = 1'b0;
    if (ack) begin
      chk("R11", "ackDone", 32'(ackDone), 32'd1);
      chk(expNone ? "R9" : (expSpur ? "R5" : "R6"), "ackNone", 32'(ackNone), 32'(expNone));
      chk(expNone ? "R9" : (expSpur ? "R5" : "R6"), "ackSpur", 32'(ackSpur), 32'(expSpur));
      chk(expSpur ? "R5" : "R2", "ackVector", 32'(ackVector), 32'(expVec));
      chk("R1", "ackLevel", 32'(ackLevel), 32'(expLvl));
      if (!expNone && !expSpur) begin
        mReq[r] = 1'b0;
        mSvc[r] = 1'b1;
      end
    end else begin
      chk("R11", "ackDone idle", 32'(ackDone), 32'd0);
      if (eoi) begin
        s = topOf(mSvc);
        if (s >= 0) mSvc[s] = 1'b0;
      end else if (acc) begin
        if (!mReq[v]) mCount++;
        mReq[v] = 1'b1;
        mTrg[v] = lvl;
      end
    end
    checkState();
  endtask

  task automatic doAccept(input int v, input bit lvl);
    opCycle(1'b1, v, lvl, 1'b0, 1'b0);
  endtask
  task automatic doAck();
    opCycle(1'b0, 0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic doEoi();
    opCycle(1'b0, 0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic writeTpr(input int v);
    @(negedge clk);
    tprWrite = 1'b1; tprData = 8'(v);
    @(posedge clk);
    #1;
    tprWrite = 1'b0;
    mTpr = 8'(v);
    checkState();
  endtask

  task automatic writeSvr(input int v);
    @(negedge clk);
    svrWrite = 1'b1; svrData = 9'(v);
    @(posedge clk);
    #1;
    svrWrite = 1'b0;
    mSvr = 9'(v);
    checkState();
  endtask

  // empty all flags through the ports (block must be enabled)
  task automatic drain();
    writeTpr(0);
    for (int k = 0; k < 256 && mReq != 0; k++) doAck();
    for (int k = 0; k < 256 && mSvc != 0; k++) doEoi();
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R8 reset state
    checkState();
    chk("R8", "ackDone", 32'(ackDone), 32'd0);

    // R8 disabled: request recorded, no pending, ack gives none
    doAccept(8'h50, 1'b0);
    doAck();
    writeSvr(9'h1FF);
    doAck();
    doEoi();
    doEoi(); // R7 nothing in service

    // R4 R5 R6 sweep of task-priority class against request class
    for (int t = 0; t < 16; t++) begin
      for (int c = 1; c < 16; c++) begin
        writeTpr(t == 0 ? 0 : (t * 16 + 8));
        doAccept(c * 16 + ((c * 7) % 16), c[0]);
        doAck();
        drain();
      end
    end

    // R3 in-service class against task priority
    writeTpr(8'h20);
    doAccept(8'h95, 1'b0);
    doAck();
    chk("R3", "prio from service", 32'(procPrio), 32'h90);
    writeTpr(8'hA5);
    writeTpr(8'h90);
    doAccept(8'h97, 1'b0); // R4 same class: not pending
    chk("R4", "same class quiet", 32'(intPending), 32'd0);
    doAck(); // full compare: 0x97 > 0x90, taken
    drain();

    // R7 nested retire and R1 level flag, R2 ordering
    doAccept(8'h40, 1'b1);
    doAccept(8'h80, 1'b0);
    doAccept(8'h7F, 1'b1);
    doAck();
    doAck();
    chk("R2", "second pick", 32'(ackVector), 32'h7F);
    doAck();
    doEoi();
    chk("R7", "after first eoi", 32'(procPrio), 32'h70);
    doEoi();
    chk("R7", "after second eoi", 32'(procPrio), 32'h40);
    doEoi();
    doEoi();

    // R10 duplicate accept
    cnt0 = mCount;
    doAccept(8'h33, 1'b0);
    doAccept(8'h33, 1'b1);
    chk("R10", "duplicate", 32'(newReqCount), 32'(cnt0 + 1));
    drain();

    // R11 collisions
    doAccept(8'h60, 1'b0);
    cnt0 = mCount;
    opCycle(1'b1, 8'hE0, 1'b0, 1'b1, 1'b0);
    chk("R11", "accept dropped by ack", 32'(newReqCount), 32'(cnt0));
    opCycle(1'b1, 8'hE1, 1'b0, 1'b0, 1'b1);
    chk("R11", "accept dropped by eoi", 32'(intPending), 32'd0);
    doAck(); // R9 nothing requested

    // R5 spurious vector value, R8 disable with pending
    writeSvr(9'h1AB);
    writeTpr(8'hF0);
    doAccept(8'h21, 1'b1);
    doAck();
    chk("R5", "spurious value", 32'(ackVector), 32'hAB);
    writeTpr(0);
    writeSvr(9'h0AB);
    doAck();
    writeSvr(9'h1AB);
    drain();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule